// File: doc/BRIEF.md
# Runahead Poison Tracking Controller

This block sits behind an in-order issue stage. It holds issued instructions in a small in-order window and executes the oldest one each cycle. A load that misses off-chip stays at the head of the window and blocks retirement, while younger instructions keep filling the window behind it. When the window is full and its oldest entry is still waiting on that miss, the controller does four things. It saves a copy of the register file, records the program counter of the blocked load, drops that load and marks its destination register as poisoned. It then moves into a speculative mode.

In speculative mode every instruction still executes, but each one carries a poison bit from its sources to its destination. A load that would go off-chip and whose address register is clean becomes a prefetch request, which overlaps further memory traffic with the outstanding miss. When the blocking miss returns, the controller discards everything it did speculatively. It restores the saved register copy, clears all poison, flushes the window and pulses a restart request carrying the blocked load's program counter. The issue stage then re-sends every instruction from that point onward.

The instruction set seen by the block has four classes: no-op, load-immediate, register add and load. A load's address is the value of its first source register. Caches, memory and branch handling lie outside the block. A load that hits returns a fixed function of its address, which stands in for the cache.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the block is in normal mode, iss_ready is 1, and wb_valid, pf_valid and restart_valid are 0.
- R2: In normal mode, instructions execute in issue order. An instruction executes on the clock edge after the edge on which it became the window head, and it reports wb_valid one cycle later with wb_poison 0. The results are: load-immediate (class 1) writes iss_imm; add (class 2) writes the sum of its two source registers; a load that hits (class 3, iss_miss 0) writes ((addr << 1) XOR 0x5A), where addr is the value of source A. A no-op (class 0) reports nothing.
- R3: In normal mode, a missing load at the head blocks all execution. The window never holds more than DEPTH entries, and iss_ready is 0 while it is full. Speculative mode begins on the first clock edge at which the window holds DEPTH entries and its head is a missing load.
- R4: On entry to speculative mode, restart_pc takes the blocked load's program counter. The blocked load produces no write-back, and its destination register becomes poisoned.
- R5: In speculative mode, an add with at least one poisoned source, or a load with a poisoned address, reports wb_poison 1. A load-immediate, or an instruction whose sources are all clean, reports wb_poison 0 with its normal value and clears its destination's poison.
- R6: In speculative mode, a missing load with a clean address register raises pf_valid for one cycle, in the same cycle as its write-back, with pf_addr equal to the address. Its destination becomes poisoned.
- R7: In speculative mode, a missing load whose address register is poisoned issues no prefetch and poisons its destination.
- R8: A miss_ret pulse in speculative mode causes three things. In that cycle iss_ready is 0, and the window head does not execute. On the next edge the block returns to normal mode with the window emptied. restart_valid is 1 for exactly one cycle with restart_pc unchanged.
- R9: After restart, every register holds the value it had when speculative mode began, and no register is poisoned.
- R10: A miss_ret pulse in normal mode has no effect: the mode, the window and restart_valid are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_opc | input | 2 | Class: 0 no-op, 1 load-immediate, 2 add, 3 load |
| iss_src_a | input | 3 | First source register (load address) |
| iss_src_b | input | 3 | Second source register (add only) |
| iss_dst | input | 3 | Destination register |
| iss_imm | input | 16 | Immediate for load-immediate |
| iss_pc | input | 16 | Program counter of the instruction |
| iss_miss | input | 1 | Load goes off-chip |
| iss_ready | output | 1 | Issue accepted this cycle when valid |
| miss_ret | input | 1 | Blocking off-chip access has returned |
| wb_valid | output | 1 | An instruction executed |
| wb_idx | output | 3 | Its destination register |
| wb_data | output | 16 | Its result value |
| wb_poison | output | 1 | Its result is poisoned |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | 16 | Prefetch address |
| ra_mode | output | 1 | Speculative mode active |
| restart_valid | output | 1 | Restart fetch request pulse |
| restart_pc | output | 16 | Program counter to restart from |

## Verification
The bench builds the block with its default parameters: a window of four entries, eight registers and sixteen-bit data. With these values, one blocked load plus three younger instructions are enough to reach the exact edge on which speculative mode begins. Every register can also be named individually, so the bench can check for each one both the value restored from the checkpoint and the clearing of its poison bit. The same short window lets the bench leave one instruction at the head exactly when the miss returns, which shows that the flush discards it.

// File: rtl/ra_pkg.sv
package ra_pkg;

  typedef enum logic [1:0] {
    OPC_NOP  = 2'd0,
    OPC_LI   = 2'd1,
    OPC_ADD  = 2'd2,
    OPC_LOAD = 2'd3
  } opc_e;

  // poison of a result from the poison of its operands
  function automatic logic result_poison(input opc_e op, input logic pa,
                                         input logic pb, input logic miss);
    case (op)
      OPC_ADD:  return pa | pb;
      OPC_LOAD: return pa | miss;
      default:  return 1'b0;
    endcase
  endfunction

  // a load needs a prefetch only when its address is known
  function automatic logic wants_prefetch(input opc_e op, input logic pa,
                                          input logic miss);
    return (op == OPC_LOAD) && miss && !pa;
  endfunction

endpackage

// File: rtl/ra_window.sv
module ra_window #(
  parameter int DEPTH = 4,
  parameter int EW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic          head_valid,
  output logic [EW-1:0] head_data,
  output logic [CW-1:0] count
);

  logic [EW-1:0] slot_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) slot_q[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_valid = (cnt_q != '0);
  assign head_data  = slot_q[rd_ptr_q];
  assign count      = cnt_q;

endmodule

// File: rtl/ra_regfile.sv
module ra_regfile #(
  parameter int NREGS = 8,
  parameter int XLEN  = 16,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_a_idx,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ckpt_take,
  input  logic            ckpt_restore
);

  logic [XLEN-1:0] arch_w [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [XLEN-1:0] val_q;
    logic [XLEN-1:0] ck_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        ck_q  <= '0;
      end else begin
        if (ckpt_restore)                     val_q <= ck_q;
        else if (we && wr_idx == AW'(g))      val_q <= wr_data;
        if (ckpt_take)                        ck_q  <= val_q;
      end
    end
    assign arch_w[g] = val_q;
  end

  assign rd_a = arch_w[rd_a_idx];
  assign rd_b = arch_w[rd_b_idx];

endmodule

// File: rtl/ra_poison.sv
module ra_poison #(
  parameter int NREGS = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_a_idx,
  input  logic [AW-1:0]    rd_b_idx,
  output logic             pa,
  output logic             pb,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic             wr_poison,
  input  logic             mark_en,
  input  logic [AW-1:0]    mark_idx,
  input  logic             clear_all,
  output logic [NREGS-1:0] poison_vec
);

  logic [NREGS-1:0] poison_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poison_q <= '0;
    end else if (clear_all) begin
      poison_q <= '0;
    end else begin
      if (mark_en) poison_q[mark_idx] <= 1'b1;
      if (wr_en)   poison_q[wr_idx]   <= wr_poison;
    end
  end

  assign pa         = poison_q[rd_a_idx];
  assign pb         = poison_q[rd_b_idx];
  assign poison_vec = poison_q;

endmodule

// File: rtl/ra_mode_ctrl.sv
module ra_mode_ctrl #(
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           win_full,
  input  logic           head_valid,
  input  logic           head_block,
  input  logic [PCW-1:0] head_pc,
  input  logic           miss_ret,
  output logic           enter_evt,
  output logic           exit_evt,
  output logic           ra_mode,
  output logic           restart_valid,
  output logic [PCW-1:0] restart_pc
);

  logic           ra_q;
  logic           rst_pulse_q;
  logic [PCW-1:0] rpc_q;

  assign enter_evt = !ra_q && win_full && head_valid && head_block;
  assign exit_evt  = ra_q && miss_ret;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q        <= 1'b0;
      rst_pulse_q <= 1'b0;
      rpc_q       <= '0;
    end else begin
      if (enter_evt)     ra_q <= 1'b1;
      else if (exit_evt) ra_q <= 1'b0;
      rst_pulse_q <= exit_evt;
      if (enter_evt) rpc_q <= head_pc;
    end
  end

  assign ra_mode       = ra_q;
  assign restart_valid = rst_pulse_q;
  assign restart_pc    = rpc_q;

endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
  import ra_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int NREGS = 8,
  parameter int XLEN  = 16,
  parameter int PCW   = 16,
  localparam int AW   = $clog2(NREGS),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [1:0]      iss_opc,
  input  logic [AW-1:0]   iss_src_a,
  input  logic [AW-1:0]   iss_src_b,
  input  logic [AW-1:0]   iss_dst,
  input  logic [XLEN-1:0] iss_imm,
  input  logic [PCW-1:0]  iss_pc,
  input  logic            iss_miss,
  output logic            iss_ready,
  input  logic            miss_ret,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            wb_poison,
  output logic            pf_valid,
  output logic [XLEN-1:0] pf_addr,
  output logic            ra_mode,
  output logic            restart_valid,
  output logic [PCW-1:0]  restart_pc
);

  localparam int OFS_MISS = 0;
  localparam int OFS_PC   = OFS_MISS + 1;
  localparam int OFS_IMM  = OFS_PC + PCW;
  localparam int OFS_DST  = OFS_IMM + XLEN;
  localparam int OFS_B    = OFS_DST + AW;
  localparam int OFS_A    = OFS_B + AW;
  localparam int OFS_OPC  = OFS_A + AW;
  localparam int EW       = OFS_OPC + 2;

  function automatic logic [XLEN-1:0] add_value(input logic [XLEN-1:0] x,
                                                input logic [XLEN-1:0] y);
    return x + y;
  endfunction

  function automatic logic [XLEN-1:0] hit_value(input logic [XLEN-1:0] addr);
    return (addr << 1) ^ XLEN'(8'h5A);
  endfunction

  // named internal events
  logic            enter_evt, exit_evt, exec_fire, pf_fire, win_full;
  logic            push, pop;
  logic [CW-1:0]   win_cnt;
  logic            head_valid;
  logic [EW-1:0]   head_data, push_data;
  opc_e            head_opc;
  logic [AW-1:0]   head_a, head_b, head_dst;
  logic [XLEN-1:0] head_imm;
  logic [PCW-1:0]  head_pc;
  logic            head_miss, head_block;
  logic [XLEN-1:0] val_a, val_b, res_value;
  logic            pa, pb, res_poison, wr_en;
  logic [NREGS-1:0] poison_vec;

  assign push_data = {iss_opc, iss_src_a, iss_src_b, iss_dst, iss_imm, iss_pc, iss_miss};

  assign head_opc   = opc_e'(head_data[OFS_OPC +: 2]);
  assign head_a     = head_data[OFS_A +: AW];
  assign head_b     = head_data[OFS_B +: AW];
  assign head_dst   = head_data[OFS_DST +: AW];
  assign head_imm   = head_data[OFS_IMM +: XLEN];
  assign head_pc    = head_data[OFS_PC +: PCW];
  assign head_miss  = head_data[OFS_MISS];
  assign head_block = (head_opc == OPC_LOAD) && head_miss;

  assign win_full  = (win_cnt == CW'(DEPTH));
  assign iss_ready = !win_full && !exit_evt;
  assign push      = iss_valid && iss_ready;
  assign exec_fire = head_valid && !exit_evt && !enter_evt && (ra_mode || !head_block);
  assign pop       = exec_fire || enter_evt;
  assign wr_en     = exec_fire && (head_opc != OPC_NOP);
  assign pf_fire   = exec_fire && ra_mode && wants_prefetch(head_opc, pa, head_miss);

  always_comb begin
    case (head_opc)
      OPC_LI:   res_value = head_imm;
      OPC_ADD:  res_value = add_value(val_a, val_b);
      OPC_LOAD: res_value = hit_value(val_a);
      default:  res_value = '0;
    endcase
    res_poison = result_poison(head_opc, pa, pb, head_miss);
  end

  ra_window #(.DEPTH(DEPTH), .EW(EW)) u_window (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .flush(exit_evt), .head_valid(head_valid),
    .head_data(head_data), .count(win_cnt)
  );

  ra_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(head_a), .rd_b_idx(head_b),
    .rd_a(val_a), .rd_b(val_b), .we(wr_en), .wr_idx(head_dst),
    .wr_data(res_value), .ckpt_take(enter_evt), .ckpt_restore(exit_evt)
  );

  ra_poison #(.NREGS(NREGS)) u_poison (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(head_a), .rd_b_idx(head_b),
    .pa(pa), .pb(pb), .wr_en(wr_en), .wr_idx(head_dst),
    .wr_poison(res_poison), .mark_en(enter_evt), .mark_idx(head_dst),
    .clear_all(exit_evt), .poison_vec(poison_vec)
  );

  ra_mode_ctrl #(.PCW(PCW)) u_mode (
    .clk(clk), .rst_n(rst_n), .win_full(win_full), .head_valid(head_valid),
    .head_block(head_block), .head_pc(head_pc), .miss_ret(miss_ret),
    .enter_evt(enter_evt), .exit_evt(exit_evt), .ra_mode(ra_mode),
    .restart_valid(restart_valid), .restart_pc(restart_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      wb_poison <= 1'b0;
      pf_valid  <= 1'b0;
      pf_addr   <= '0;
    end else begin
      wb_valid  <= wr_en;
      wb_idx    <= head_dst;
      wb_data   <= res_value;
      wb_poison <= wr_en && res_poison;
      pf_valid  <= pf_fire;
      pf_addr   <= val_a;
    end
  end

endmodule

// File: rtl/ra_checker.sv
module ra_checker #(
  parameter int DEPTH = 4,
  parameter int NREGS = 8,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ra_mode,
  input logic             miss_ret,
  input logic             restart_valid,
  input logic             enter_evt,
  input logic [CW-1:0]    win_cnt,
  input logic             pf_valid,
  input logic             wb_valid,
  input logic             wb_poison,
  input logic [NREGS-1:0] poison_vec
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CW'(DEPTH));

  p_enter_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ra_mode) |-> $past(win_cnt) == CW'(DEPTH));

  p_exit_on_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode && miss_ret) |=> (!ra_mode && restart_valid));

  p_restart_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |=> !restart_valid);

  p_ignore_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_mode && miss_ret && !enter_evt) |=> (!ra_mode && !restart_valid));

  p_prefetch_in_ra_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(ra_mode));

  p_poison_in_ra_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_poison) |-> $past(ra_mode));

  p_poison_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |-> (poison_vec == '0));

endmodule

bind runahead_ctrl ra_checker #(.DEPTH(DEPTH), .NREGS(NREGS), .CW(CW)) u_ra_checker (
  .clk(clk), .rst_n(rst_n), .ra_mode(ra_mode), .miss_ret(miss_ret),
  .restart_valid(restart_valid), .enter_evt(enter_evt), .win_cnt(win_cnt),
  .pf_valid(pf_valid), .wb_valid(wb_valid), .wb_poison(wb_poison),
  .poison_vec(poison_vec)
);

// File: tb/test_runahead_ctrl.sv
`timescale 1ns/1ps
module test_runahead_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_opc = 2'd0;
  logic [2:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic [15:0] iss_imm = '0, iss_pc = '0;
  logic        iss_miss = 1'b0;
  logic        iss_ready;
  logic        miss_ret = 1'b0;
  logic        wb_valid, wb_poison, pf_valid, ra_mode, restart_valid;
  logic [2:0]  wb_idx;
  logic [15:0] wb_data, pf_addr, restart_pc;

  always #4 clk = ~clk;

  runahead_ctrl i_runahead_ctrl (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_opc(iss_opc),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .iss_imm(iss_imm), .iss_pc(iss_pc), .iss_miss(iss_miss),
    .iss_ready(iss_ready), .miss_ret(miss_ret), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .wb_poison(wb_poison),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .ra_mode(ra_mode),
    .restart_valid(restart_valid), .restart_pc(restart_pc)
  );

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 0;

  int    q_idx[$];
  int    q_data[$];
  bit    q_poi[$];
  string q_req[$];
  int    q_pf[$];

  localparam logic [1:0] NOP = 2'd0, LI = 2'd1, ADD = 2'd2, LD = 2'd3;

  function automatic int hit(input int a);
    return ((a * 2) ^ 'h5A) & 'hFFFF;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_wb(input int idx, input int data, input bit poi, input string req);
    q_idx.push_back(idx); q_data.push_back(data);
    q_poi.push_back(poi); q_req.push_back(req);
  endtask

  task automatic issue(input logic [1:0] op, input int a, input int b, input int d,
                       input int imm, input int pc, input bit miss);
    iss_valid = 1'b1; iss_opc = op;
    iss_src_a = 3'(a); iss_src_b = 3'(b); iss_dst = 3'(d);
    iss_imm = 16'(imm); iss_pc = 16'(pc); iss_miss = miss;
    while (!iss_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    iss_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      if (q_idx.size() == 0) begin
        check(0, "R2/R4/R8", "unexpected write-back idx", int'(wb_idx), -1);
      end else begin
        automatic int ei = q_idx.pop_front();
        automatic int ed = q_data.pop_front();
        automatic bit ep = q_poi.pop_front();
        automatic string er = q_req.pop_front();
        check(int'(wb_idx) == ei, er, "wb_idx", int'(wb_idx), ei);
        check(wb_poison == ep, er, "wb_poison", int'(wb_poison), int'(ep));
        if (!ep) check(int'(wb_data) == ed, er, "wb_data", int'(wb_data), ed);
      end
    end
    if (rst_n && pf_valid) begin
      if (q_pf.size() == 0) begin
        check(0, "R7", "unexpected prefetch addr", int'(pf_addr), -1);
      end else begin
        automatic int ea = q_pf.pop_front();
        check(int'(pf_addr) == ea, "R6", "pf_addr", int'(pf_addr), ea);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ra_mode == 0, "R1", "ra_mode", int'(ra_mode), 0);
    check(iss_ready == 1, "R1", "iss_ready", int'(iss_ready), 1);
    check(!wb_valid && !pf_valid && !restart_valid, "R1", "outputs idle",
          int'({wb_valid, pf_valid, restart_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 normal execution
    issue(LI, 0, 0, 1, 5, 'h10, 0);   expect_wb(1, 5, 0, "R2");
    issue(LI, 0, 0, 2, 7, 'h11, 0);   expect_wb(2, 7, 0, "R2");
    issue(NOP, 0, 0, 6, 0, 'h12, 0);
    issue(LD, 2, 0, 3, 0, 'h13, 0);   expect_wb(3, hit(7), 0, "R2");
    idle(3);

    // blocking miss at head
    issue(LD, 1, 0, 4, 0, 'h14, 1);
    idle(2);
    // R10 return strobe in normal mode
    miss_ret = 1'b1; @(negedge clk); miss_ret = 1'b0; @(negedge clk);
    check(ra_mode == 0, "R10", "ra_mode after stray return", int'(ra_mode), 0);
    check(restart_valid == 0, "R10", "restart_valid", int'(restart_valid), 0);

    issue(ADD, 4, 2, 5, 0, 'h15, 0);
    issue(LD, 2, 0, 6, 0, 'h16, 1);
    issue(ADD, 1, 2, 7, 0, 'h17, 0);
    iss_valid = 1'b0;
    expect_wb(5, 0, 1, "R5");          // r4 poisoned by blocked load
    expect_wb(6, 0, 1, "R6");          // prefetched miss poisons dst
    q_pf.push_back(7);                 // R6 prefetch of address 7
    expect_wb(7, 12, 0, "R5");
    // R3 window full, entry on the next edge
    check(ra_mode == 0, "R3", "ra_mode when just full", int'(ra_mode), 0);
    check(iss_ready == 0, "R3", "iss_ready when full", int'(iss_ready), 0);
    @(negedge clk);
    check(ra_mode == 1, "R3", "ra_mode after entry", int'(ra_mode), 1);
    check(restart_pc == 16'h14, "R4", "restart_pc", int'(restart_pc), 'h14);
    idle(4);

    issue(LD, 5, 0, 0, 0, 'h18, 1);    expect_wb(0, 0, 1, "R7");
    issue(ADD, 7, 4, 3, 0, 'h19, 0);   expect_wb(3, 0, 1, "R4");
    issue(LI, 0, 0, 5, 3, 'h1A, 0);    expect_wb(5, 3, 0, "R5");
    issue(ADD, 5, 7, 1, 0, 'h1B, 0);   expect_wb(1, 15, 0, "R5");
    issue(LD, 7, 0, 2, 0, 'h1C, 0);    expect_wb(2, hit(12), 0, "R5");
    idle(5);

    // R8 return with one instruction still at the head
    issue(LI, 0, 0, 3, 99, 'h1D, 0);
    miss_ret = 1'b1;
    iss_valid = 1'b1; iss_opc = LI; iss_dst = 3'd3; iss_imm = 16'd55;
    #1;
    check(iss_ready == 0, "R8", "iss_ready on return cycle", int'(iss_ready), 0);
    @(negedge clk);
    miss_ret = 1'b0; iss_valid = 1'b0;
    check(restart_valid == 1, "R8", "restart_valid", int'(restart_valid), 1);
    check(restart_pc == 16'h14, "R8", "restart_pc", int'(restart_pc), 'h14);
    check(ra_mode == 0, "R8", "ra_mode after return", int'(ra_mode), 0);
    @(negedge clk);
    check(restart_valid == 0, "R8", "restart pulse width", int'(restart_valid), 0);

    // R9 restored registers, poison cleared
    issue(ADD, 1, 7, 3, 0, 'h14, 0);   expect_wb(3, 5, 0, "R9");
    issue(ADD, 4, 2, 0, 0, 'h15, 0);   expect_wb(0, 7, 0, "R9");
    issue(ADD, 5, 6, 6, 0, 'h16, 0);   expect_wb(6, 0, 0, "R9");
    issue(ADD, 3, 2, 4, 0, 'h17, 0);   expect_wb(4, 5 + 7, 0, "R9");
    issue(ADD, 2, 2, 1, 0, 'h18, 0);   expect_wb(1, 14, 0, "R9");
    idle(6);

    check(q_idx.size() == 0, "R2", "write-backs outstanding", q_idx.size(), 0);
    check(q_pf.size() == 0, "R6", "prefetches outstanding", q_pf.size(), 0);
    check(ra_mode == 0, "R9", "mode at end", int'(ra_mode), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule